// File: doc/BRIEF.md
# Unlock-Sequenced Configuration Index Port

This block gives a host access to a chip's configuration registers through two I/O addresses: an index port and a data port at the next address up. The registers are hidden until the host writes the key byte 83h twice in a row to the index port. Once the block is unlocked, each further index-port write selects a register and the data port reads or writes that register. Writing AAh to the index port hides the registers again.

The index space has two parts. Indices below 30h reach global registers: a device-select register, read-only identification bytes, a few control bytes, a lock bit and a self-clearing software reset. Indices 30h and above reach a bank of registers that belongs to the logical device currently selected. A strap input is captured just after reset is released, and it decides which of two address pairs the block answers on.

A plain strobe interface stands in for the host bus. A write is taken at the rising clock edge where `io_wr_i` is high. Read data is combinational and is qualified by `io_rd_i`.

Top module: `cfg_index_port`

## Requirements
- R1: Two consecutive index-port writes of 83h enter configuration mode. `cfg_mode_o` is 1 from the clock edge that takes the second write.
- R2: The second write enters configuration mode only if it is also 83h to the index port. Any other index-port value, or any data-port write, between the two key writes returns the sequence to its start.
- R3: In configuration mode, an index-port write of AAh leaves the mode. Any other value is stored as the index, so AAh can never be used as an index.
- R4: On the first clock after reset is released, `strap_i` is captured. A strap of 1 places the ports at 2Eh/2Fh and clears bit 6 of global register 26h. A strap of 0 places them at 4Eh/4Fh and sets that bit. Writing bit 6 moves the pair at once (0 = 2Eh/2Fh, 1 = 4Eh/4Fh), and `port_hi_o` shows its value. Accesses to any other address have no effect.
- R5: `io_rdata_o` is FFh unless `io_rd_i` is high at the active data port while configuration mode is on and access is permitted. Reads of the index port return FFh.
- R6: Global 20h reads 71h and global 21h reads {1h, REV}. Writes to either are ignored.
- R7: Global registers and their reset values: 07h is a full byte, default 00h. 22h keeps bits 7:5, default 80h. 23h keeps bits 7:4, default 00h. 29h keeps bits 7:4, default 00h. 26h keeps bits 6:5. All other bits and global indices read 0.
- R8: Global 07h selects the logical device for indices 30h and above. Devices 0 to NDEV-1 each have their own bank. With any other selection, bank reads return 00h and bank writes are ignored.
- R9: Each bank holds 30h (bit 0 only), 60h, 61h, 70h (bits 3:0), F0h and F1h. Every register defaults to 00h except F0h of device 2, which defaults to FFh. Other bank indices read 00h.
- R10: Bit 5 of 26h locks the registers. While it is set, only index 26h can be read or written: reads of other indices return FFh and writes to them are ignored.
- R11: A data write with bit 0 set to global 02h pulses `swrst_o` high for one cycle. It returns every register to its default, except bit 6 of 26h, which keeps its value. Configuration mode and the index are kept. Index 02h reads 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_i | input | 1 | Port-pair strap, captured after reset |
| io_addr_i | input | ADDR_W | I/O address of the current access |
| io_wr_i | input | 1 | Write strobe |
| io_rd_i | input | 1 | Read strobe |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Read data, FFh when not driven by a register |
| cfg_mode_o | output | 1 | Configuration mode is on |
| swrst_o | output | 1 | One-cycle software reset pulse |
| ldn_o | output | 8 | Selected logical device |
| port_hi_o | output | 1 | 1 when the ports are at 4Eh/4Fh |

## Verification
Some rules are checked by assertions on every cycle. Configuration mode can only be entered from the half-unlocked state on a key write. A data write in that state, or an exit key, sends the state machine back to its start. The read data is FFh whenever the mode is off. The reset pulse lasts one cycle and leaves the device select cleared, and a locked write cannot change the device select. Other behaviour can only be shown by the bench's scenarios: the full sweep of second unlock bytes, the default contents of every index, the separation between banks, the strap choice across two resets, the port pair moving when it is written, and which registers survive a software reset.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_HALF, ST_OPEN} unlock_e;

  localparam logic [7:0] KEY_ENTER = 8'h83;
  localparam logic [7:0] KEY_EXIT  = 8'hAA;
  localparam logic [7:0] BANK_LO   = 8'h30;
  localparam int         NSLOT     = 6;

  function automatic logic [7:0] slot_idx(int s);
    case (s)
      0:       return 8'h30;
      1:       return 8'h60;
      2:       return 8'h61;
      3:       return 8'h70;
      4:       return 8'hF0;
      default: return 8'hF1;
    endcase
  endfunction

  function automatic logic [7:0] slot_mask(int s);
    case (s)
      0:       return 8'h01;
      3:       return 8'h0F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] slot_dflt(int d, int s);
    return (d == 2 && s == 4) ? 8'hFF : 8'h00;
  endfunction
endpackage

// File: rtl/cfgp_unlock.sv
module cfgp_unlock
  import cfgp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idx_wr_i,
  input  logic       dat_wr_i,
  input  logic [7:0] wdata_i,
  output logic       open_o,
  output logic [7:0] idx_o
);
  unlock_e    state_q;
  logic [7:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= 8'h00;
    end else begin
      case (state_q)
        ST_IDLE: if (idx_wr_i && wdata_i == KEY_ENTER) state_q <= ST_HALF;
        ST_HALF: begin
          if (idx_wr_i && wdata_i == KEY_ENTER) state_q <= ST_OPEN;
          else if (idx_wr_i || dat_wr_i)        state_q <= ST_IDLE;
        end
        ST_OPEN: if (idx_wr_i) begin
          if (wdata_i == KEY_EXIT) state_q <= ST_IDLE;
          else                     idx_q   <= wdata_i;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign open_o = (state_q == ST_OPEN);
  assign idx_o  = idx_q;

  a_r1_open_needs_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OPEN && $past(state_q) != ST_OPEN) |->
      ($past(state_q) == ST_HALF && $past(idx_wr_i) && $past(wdata_i) == KEY_ENTER));

  a_r2_data_write_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HALF && dat_wr_i) |=> state_q == ST_IDLE);

  a_r3_exit_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OPEN && idx_wr_i && wdata_i == KEY_EXIT) |=> state_q == ST_IDLE);
endmodule

// File: rtl/cfgp_global.sv
module cfgp_global #(
  parameter logic [3:0] REV = 4'h3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       strap_i,
  input  logic       wr_i,
  input  logic [7:0] idx_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic [7:0] ldn_o,
  output logic       lock_o,
  output logic       base_sel_o,
  output logic       clr_o,
  output logic       swrst_o
);
  logic [7:0] ldn_q;
  logic [2:0] pwr_q;
  logic [3:0] pme_q;
  logic [3:0] mux_q;
  logic       lock_q, base_sel_q, cap_done_q, swrst_q;

  assign clr_o = wr_i && idx_i == 8'h02 && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ldn_q      <= 8'h00;
      pwr_q      <= 3'b100;
      pme_q      <= 4'h0;
      mux_q      <= 4'h0;
      lock_q     <= 1'b0;
      base_sel_q <= 1'b0;
      cap_done_q <= 1'b0;
      swrst_q    <= 1'b0;
    end else begin
      swrst_q <= 1'b0;
      if (!cap_done_q) begin
        cap_done_q <= 1'b1;
        base_sel_q <= ~strap_i;
      end
      if (clr_o) begin
        swrst_q <= 1'b1;
        ldn_q   <= 8'h00;
        pwr_q   <= 3'b100;
        pme_q   <= 4'h0;
        mux_q   <= 4'h0;
        lock_q  <= 1'b0;
      end else if (wr_i) begin
        case (idx_i)
          8'h07: ldn_q <= wdata_i;
          8'h22: pwr_q <= wdata_i[7:5];
          8'h23: pme_q <= wdata_i[7:4];
          8'h26: begin
            base_sel_q <= wdata_i[6];
            lock_q     <= wdata_i[5];
          end
          8'h29: mux_q <= wdata_i[7:4];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (idx_i)
      8'h07:   rdata_o = ldn_q;
      8'h20:   rdata_o = 8'h71;
      8'h21:   rdata_o = {4'h1, REV};
      8'h22:   rdata_o = {pwr_q, 5'b0};
      8'h23:   rdata_o = {pme_q, 4'b0};
      8'h26:   rdata_o = {1'b0, base_sel_q, lock_q, 5'b0};
      8'h29:   rdata_o = {mux_q, 4'b0};
      default: rdata_o = 8'h00;
    endcase
  end

  assign ldn_o      = ldn_q;
  assign lock_o     = lock_q;
  assign base_sel_o = base_sel_q;
  assign swrst_o    = swrst_q;
endmodule

// File: rtl/cfgp_bank.sv
module cfgp_bank
  import cfgp_pkg::*;
#(
  parameter int NDEV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       wr_i,
  input  logic [7:0] ldn_i,
  input  logic [7:0] idx_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o
);
  logic [7:0] regs_q [NDEV][NSLOT];

  for (genvar d = 0; d < NDEV; d++) begin : g_dev
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          regs_q[d][s] <= slot_dflt(d, s);
        else if (clr_i)
          regs_q[d][s] <= slot_dflt(d, s);
        else if (wr_i && ldn_i == 8'(d) && idx_i == slot_idx(s))
          regs_q[d][s] <= wdata_i & slot_mask(s);
      end
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    for (int d = 0; d < NDEV; d++)
      for (int s = 0; s < NSLOT; s++)
        if (ldn_i == 8'(d) && idx_i == slot_idx(s)) rdata_o = regs_q[d][s];
  end
endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
  import cfgp_pkg::*;
#(
  parameter int         ADDR_W  = 16,
  parameter int         NDEV    = 4,
  parameter logic [3:0] REV     = 4'h3,
  parameter logic [7:0] BASE_LO = 8'h2E,
  parameter logic [7:0] BASE_HI = 8'h4E
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strap_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [7:0]        io_wdata_i,
  output logic [7:0]        io_rdata_o,
  output logic              cfg_mode_o,
  output logic              swrst_o,
  output logic [7:0]        ldn_o,
  output logic              port_hi_o
);
  logic [ADDR_W-1:0] idx_addr, dat_addr;
  logic idx_hit, dat_hit, idx_wr, dat_wr;
  logic open, lock, base_sel, clr, acc_ok, is_glb;
  logic [7:0] idx, ldn, g_rd, b_rd;

  assign idx_addr = ADDR_W'(base_sel ? BASE_HI : BASE_LO);
  assign dat_addr = idx_addr + ADDR_W'(1);
  assign idx_hit  = io_addr_i == idx_addr;
  assign dat_hit  = io_addr_i == dat_addr;
  assign idx_wr   = io_wr_i && idx_hit;
  assign dat_wr   = io_wr_i && dat_hit;

  cfgp_unlock u_unlock (
    .clk_i, .rst_ni,
    .idx_wr_i (idx_wr),
    .dat_wr_i (dat_wr),
    .wdata_i  (io_wdata_i),
    .open_o   (open),
    .idx_o    (idx)
  );

  // lock leaves only the lock register reachable
  assign acc_ok = open && (!lock || idx == 8'h26);
  assign is_glb = idx < BANK_LO;

  cfgp_global #(.REV(REV)) u_global (
    .clk_i, .rst_ni, .strap_i,
    .wr_i       (dat_wr && acc_ok && is_glb),
    .idx_i      (idx),
    .wdata_i    (io_wdata_i),
    .rdata_o    (g_rd),
    .ldn_o      (ldn),
    .lock_o     (lock),
    .base_sel_o (base_sel),
    .clr_o      (clr),
    .swrst_o    (swrst_o)
  );

  cfgp_bank #(.NDEV(NDEV)) u_bank (
    .clk_i, .rst_ni,
    .clr_i   (clr),
    .wr_i    (dat_wr && acc_ok && !is_glb),
    .ldn_i   (ldn),
    .idx_i   (idx),
    .wdata_i (io_wdata_i),
    .rdata_o (b_rd)
  );

  assign io_rdata_o = (io_rd_i && dat_hit && acc_ok) ? (is_glb ? g_rd : b_rd) : 8'hFF;
  assign cfg_mode_o = open;
  assign ldn_o      = ldn;
  assign port_hi_o  = base_sel;

  a_r5_closed_reads_ff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && !open) |-> io_rdata_o == 8'hFF);

  a_r10_locked_ldn_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_wr && lock && idx != 8'h26) |=> $stable(ldn));

  a_r11_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swrst_o |=> !swrst_o);

  a_r11_ldn_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swrst_o |-> (ldn == 8'h00 && !lock));
endmodule

// File: tb/tb_cfg_index_port.sv
module tb_cfg_index_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap = 1'b1;
  logic [15:0] addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata, ldn;
  logic        cfg_mode, swrst, port_hi;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;
  logic [15:0] ia;
  logic [7:0]  v;

  always #10 clk = ~clk;

  cfg_index_port dut (
    .clk_i (clk), .rst_ni (rst_n), .strap_i (strap),
    .io_addr_i (addr), .io_wr_i (wr), .io_rd_i (rd),
    .io_wdata_i (wdata), .io_rdata_o (rdata),
    .cfg_mode_o (cfg_mode), .swrst_o (swrst), .ldn_o (ldn), .port_hi_o (port_hi)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr_io(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0; addr = 16'hFFFF;
  endtask

  task automatic rd_io(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #2 d = rdata;
    rd = 1'b0; addr = 16'hFFFF;
  endtask

  task automatic rd_idx(input logic [7:0] i, output logic [7:0] d);
    wr_io(ia, i);
    rd_io(ia + 16'd1, d);
  endtask

  task automatic wr_idx(input logic [7:0] i, input logic [7:0] d);
    wr_io(ia, i);
    wr_io(ia + 16'd1, d);
  endtask

  task automatic unlock();
    wr_io(ia, 8'hAA); wr_io(ia, 8'h83); wr_io(ia, 8'h83);
  endtask

  task automatic do_reset(input logic s);
    strap = s; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  function automatic bit is_slot(input logic [7:0] i);
    return i == 8'h30 || i == 8'h60 || i == 8'h61 || i == 8'h70 || i == 8'hF0 || i == 8'hF1;
  endfunction

  function automatic logic [7:0] msk(input logic [7:0] i);
    return i == 8'h30 ? 8'h01 : (i == 8'h70 ? 8'h0F : 8'hFF);
  endfunction

  function automatic logic [7:0] pat(input int dv, input logic [7:0] i);
    return 8'((int'(i) * 7 + dv * 61) & 255);
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual 00 expected 01");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    ia = 16'h002E;
    do_reset(1'b1);
    // reset state
    chk("R1 reset mode", 8'(cfg_mode), 8'h0);
    chk("R11 reset pulse", 8'(swrst), 8'h0);
    chk("R4 strap 1 low pair", 8'(port_hi), 8'h0);
    rd_io(16'h002F, v); chk("R5 closed read", v, 8'hFF);

    // R1/R2 sweep of the second key byte
    for (int b = 0; b < 256; b++) begin
      wr_io(ia, 8'hAA); wr_io(ia, 8'h83); wr_io(ia, 8'(b));
      chk("R2 second byte", 8'(cfg_mode), (b == 8'h83) ? 8'h1 : 8'h0);
    end
    wr_io(ia, 8'hAA); wr_io(ia, 8'h83); wr_io(16'h002F, 8'h83); wr_io(ia, 8'h83);
    chk("R2 data write restarts", 8'(cfg_mode), 8'h0);
    wr_io(ia, 8'h83);
    chk("R1 enter after restart", 8'(cfg_mode), 8'h1);

    // R3 exit
    wr_io(ia, 8'hAA);
    chk("R3 exit", 8'(cfg_mode), 8'h0);
    rd_io(16'h002F, v); chk("R5 read after exit", v, 8'hFF);

    // defaults across the index space, device 0
    unlock();
    chk("R1 unlocked", 8'(cfg_mode), 8'h1);
    for (int i = 0; i < 256; i++) begin
      logic [7:0] e;
      if (i == 8'hAA) continue;
      e = (i == 8'h20) ? 8'h71 : (i == 8'h21) ? 8'h13 : (i == 8'h22) ? 8'h80 : 8'h00;
      rd_idx(8'(i), v);
      chk((i < 8'h30) ? "R7 global default" : "R9 bank default", v, e);
    end
    rd_io(ia, v); chk("R5 index port read", v, 8'hFF);

    // R6 read-only ID
    wr_idx(8'h20, 8'h00); rd_io(ia + 16'd1, v); chk("R6 id hi", v, 8'h71);
    wr_idx(8'h21, 8'h00); rd_io(ia + 16'd1, v); chk("R6 id lo", v, 8'h13);

    // R7 masks
    wr_idx(8'h22, 8'hFF); rd_io(ia + 16'd1, v); chk("R7 mask 22", v, 8'hE0);
    wr_idx(8'h23, 8'hFF); rd_io(ia + 16'd1, v); chk("R7 mask 23", v, 8'hF0);
    wr_idx(8'h29, 8'hFF); rd_io(ia + 16'd1, v); chk("R7 mask 29", v, 8'hF0);
    wr_idx(8'h07, 8'h5C); rd_io(ia + 16'd1, v); chk("R7 ldn byte", v, 8'h5C);

    // R8/R9 bank write then readback, device 4 out of range
    for (int dv = 0; dv < 5; dv++) begin
      wr_idx(8'h07, 8'(dv));
      for (int i = 8'h30; i < 256; i++)
        if (i != 8'hAA) wr_idx(8'(i), pat(dv, 8'(i)));
    end
    for (int dv = 0; dv < 5; dv++) begin
      wr_idx(8'h07, 8'(dv));
      chk("R8 ldn out", ldn, 8'(dv));
      for (int i = 8'h30; i < 256; i++) begin
        logic [7:0] e;
        if (i == 8'hAA) continue;
        e = (dv < 4 && is_slot(8'(i))) ? (pat(dv, 8'(i)) & msk(8'(i))) : 8'h00;
        rd_idx(8'(i), v);
        chk((dv < 4) ? "R9 bank readback" : "R8 no device", v, e);
      end
    end

    // R10 lock
    wr_idx(8'h07, 8'h01);
    wr_idx(8'h26, 8'h20);
    rd_idx(8'h07, v); chk("R10 locked read", v, 8'hFF);
    wr_io(ia + 16'd1, 8'h03);
    chk("R10 locked write", ldn, 8'h01);
    rd_idx(8'h26, v); chk("R10 lock readable", v, 8'h20);
    wr_io(ia + 16'd1, 8'h00);
    rd_idx(8'h07, v); chk("R10 unlocked", v, 8'h01);

    // R4 port move
    wr_idx(8'h26, 8'h40);
    chk("R4 moved hi", 8'(port_hi), 8'h1);
    rd_io(16'h002F, v); chk("R4 old pair dead", v, 8'hFF);
    rd_io(16'h004F, v); chk("R4 new pair", v, 8'h40);
    ia = 16'h004E;

    // R11 software reset
    wr_idx(8'h22, 8'h00);
    wr_io(ia, 8'h02);
    @(negedge clk); addr = ia + 16'd1; wdata = 8'h01; wr = 1'b1;
    @(negedge clk); wr = 1'b0; addr = 16'hFFFF;
    chk("R11 pulse high", 8'(swrst), 8'h1);
    @(negedge clk);
    chk("R11 pulse low", 8'(swrst), 8'h0);
    chk("R11 mode kept", 8'(cfg_mode), 8'h1);
    rd_io(ia + 16'd1, v); chk("R11 index kept reads 02", v, 8'h00);
    rd_idx(8'h22, v); chk("R11 pwr default", v, 8'h80);
    rd_idx(8'h07, v); chk("R11 ldn default", v, 8'h00);
    rd_idx(8'h26, v); chk("R11 pair kept", v, 8'h40);
    rd_idx(8'hF0, v); chk("R11 bank cleared", v, 8'h00);
    wr_idx(8'h07, 8'h02);
    rd_idx(8'hF0, v); chk("R9 dev2 F0 default", v, 8'hFF);

    // R4 strap 0 after a new reset
    do_reset(1'b0);
    chk("R4 strap 0 high pair", 8'(port_hi), 8'h1);
    ia = 16'h002E; unlock();
    chk("R4 other address ignored", 8'(cfg_mode), 8'h0);
    ia = 16'h004E; unlock();
    chk("R4 high pair unlock", 8'(cfg_mode), 8'h1);
    rd_idx(8'h26, v); chk("R4 bit6 from strap", v, 8'h40);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule